// File: doc/BRIEF.md
# Configuration Header Register Bank

This block holds the standard type 0 configuration header of a bus target and answers configuration reads and writes. The bus-side target state machine latches the address and the command code. It registers the initiator-ready and target-ready handshake signals (both active low). It presents these to the bank together with the active-low byte enables and the write data. The bank returns a 32-bit read word. It also exposes the live contents of its writable registers, so that the rest of the device can use them for address decoding, interrupt routing and enable bits.

The identity fields are fixed parameters. These are the vendor and device identifiers, class code, revision, status word, interrupt pin and the two latency bytes. Three registers can be written: the 16-bit command word, the single memory or I/O base address register, and the interrupt-line byte. The base address register has its low bits tied off according to a size parameter. Software can therefore size the window by writing all ones and reading the value back.

Top module: `cfg_header_bank`

## Requirements
- R1: After reset the command output and the interrupt-line output are zero. The base address output is zero except bit 0, which always holds the space indicator parameter (1 for I/O, 0 for memory).
- R2: The read word is driven only while the command input is 4'b1010 (configuration read). For every other command code the read word is zero.
- R3: A register is written only when three conditions hold at one rising clock edge: the command input is 4'b1011 (configuration write), the registered initiator-ready is low and the target-ready is low. The new value is visible on the outputs after that edge. With any of the three conditions false, nothing changes.
- R4: Writes are accepted only at byte offsets 0x04, 0x10 and 0x3C, matched on address bits 7:0. A write to any other offset changes no register.
- R5: Byte enable bit i low enables byte lane i (data bits 8i+7:8i). At offset 0x04, lanes 0 and 1 write the command word, and lanes 2 and 3 are ignored because the status half is read-only.
- R6: A read at offset 0x00 returns the device identifier in bits 31:16 and the vendor identifier in bits 15:0. A read at 0x08 returns the class code in bits 31:8 and the revision in bits 7:0.
- R7: A read at offset 0x04 returns the fixed status parameter in bits 31:16 and the current command word in bits 15:0.
- R8: A read at 0x3C returns, in bits 31:24, 23:16, 15:8 and 7:0, the maximum latency, minimum grant, interrupt pin and interrupt line. Only lane 0 (interrupt line) is writable.
- R9: At offset 0x10, bits below the size exponent read as zero, apart from bit 0, which reads as the space indicator. Writing all ones therefore reads back the size mask (0xFFFFF000 for the default 4 KiB memory window). The read at 0x10 equals the base address output.
- R10: Reads at every other offset return zero. This covers 0x0C, 0x14 to 0x38, 0x40 to 0xFF and any offset not matching exactly.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_q | input | 32 | Latched transaction address; bits 7:0 select the header offset |
| cmd_q | input | 4 | Latched bus command code |
| be_n | input | 4 | Active-low byte lane enables for the data phase |
| wdata | input | 32 | Write data of the data phase |
| irdy_q_n | input | 1 | Registered initiator-ready, active low |
| trdy_n | input | 1 | Target-ready, active low |
| rdata | output | 32 | Read word for configuration reads |
| cmd_reg | output | 16 | Current command word |
| bar_reg | output | 32 | Current base address register |
| int_line | output | 8 | Current interrupt-line byte |

## Verification
The bench attempts writes with only one of the two ready signals low, and with a memory-write command while both are low. A design that ignored either handshake leg, or that checked only the low command bits, would change a register there. It writes all ones into the status half, into the read-only bytes at 0x3C and into the identity offsets 0x00, 0x08, 0x14 and 0x40. An address decoder that was too wide, or that lacked lane masking, would corrupt the command word, the interrupt line or the identity words. Single-lane writes catch swapped or inverted byte enables. The all-ones sizing write exposes a base register whose low bits are not tied off. Reads under a non-configuration command, and at reserved, device-specific and unaligned offsets, would show up as non-zero data if the read gating or the offset match were loose.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned OFS_W   = 8;
  localparam int unsigned CMDW_W  = 16;
  localparam int unsigned CMDW_LN = CMDW_W / 8;

  localparam logic [3:0] BUS_CFG_RD = 4'b1010;
  localparam logic [3:0] BUS_CFG_WR = 4'b1011;

  localparam logic [OFS_W-1:0] OFS_IDENT   = 8'h00;
  localparam logic [OFS_W-1:0] OFS_CMDSTAT = 8'h04;
  localparam logic [OFS_W-1:0] OFS_CLASS   = 8'h08;
  localparam logic [OFS_W-1:0] OFS_BASE0   = 8'h10;
  localparam logic [OFS_W-1:0] OFS_INTR    = 8'h3C;

  typedef struct packed {
    logic cmdw;
    logic base;
    logic intr;
  } wr_strobe_t;

  typedef enum logic [2:0] {
    RSEL_ZERO    = 3'd0,
    RSEL_IDENT   = 3'd1,
    RSEL_CMDSTAT = 3'd2,
    RSEL_CLASS   = 3'd3,
    RSEL_BASE    = 3'd4,
    RSEL_INTR    = 3'd5
  } rd_sel_e;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
  import cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [3:0]         cmd_q,
  input  logic [LANES-1:0]   be_n,
  input  logic               irdy_q_n,
  input  logic               trdy_n,
  output wr_strobe_t         strb,
  output logic [LANES-1:0]   lane_en
);

  logic phase_ok;

  always_comb begin
    phase_ok = (cmd_q == BUS_CFG_WR) && !irdy_q_n && !trdy_n;
  end

  always_comb begin
    strb = '0;
    if (phase_ok) begin
      unique case (ofs)
        OFS_CMDSTAT: strb.cmdw = 1'b1;
        OFS_BASE0:   strb.base = 1'b1;
        OFS_INTR:    strb.intr = 1'b1;
        default:     strb = '0;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l] = ~be_n[l];
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb)) else $error("write strobes overlap"); // R4

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_pkg::*;
#(
  parameter int unsigned BAR_SIZE_LOG2 = 12,
  parameter bit          BAR_IO        = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wr_strobe_t          strb,
  input  logic [LANES-1:0]    lane_en,
  input  logic [DATA_W-1:0]   wdata,
  output logic [CMDW_W-1:0]   cmd_q,
  output logic [DATA_W-1:0]   bar_q,
  output logic [7:0]          intl_q
);

  localparam logic [DATA_W-1:0] BAR_MASK =
    ~((DATA_W'(1) << BAR_SIZE_LOG2) - DATA_W'(1));
  localparam logic [DATA_W-1:0] BAR_FIX = {{(DATA_W-1){1'b0}}, BAR_IO};

  logic [CMDW_W-1:0]  cmd_d;
  logic [DATA_W-1:0]  bar_raw;
  logic [DATA_W-1:0]  bar_d;
  logic [7:0]         intl_d;
  logic [CMDW_LN-1:0] cmd_lane_wr;
  logic [LANES-1:0]   bar_lane_wr;
  logic               cmd_en;
  logic               bar_en;
  logic               intl_en;

  for (genvar l = 0; l < CMDW_LN; l++) begin : g_cmd_lane
    assign cmd_lane_wr[l] = strb.cmdw & lane_en[l];
    assign cmd_d[l*8 +: 8] = cmd_lane_wr[l] ? wdata[l*8 +: 8] : cmd_q[l*8 +: 8];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_bar_lane
    assign bar_lane_wr[l] = strb.base & lane_en[l];
    assign bar_raw[l*8 +: 8] = bar_lane_wr[l] ? wdata[l*8 +: 8] : bar_q[l*8 +: 8];
  end

  always_comb begin
    bar_d   = (bar_raw & BAR_MASK) | BAR_FIX;
    intl_d  = wdata[7:0];
    cmd_en  = |cmd_lane_wr;
    bar_en  = |bar_lane_wr;
    intl_en = strb.intr & lane_en[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_q <= BAR_FIX;
    end else if (bar_en) begin
      bar_q <= bar_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intl_q <= '0;
    end else if (intl_en) begin
      intl_q <= intl_d;
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.cmdw |=> $stable(cmd_q)) else $error("command word moved"); // R4
  AST_BAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.base |=> $stable(bar_q)) else $error("base register moved"); // R4
  AST_INTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.intr |=> $stable(intl_q)) else $error("interrupt line moved"); // R8

endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID     = 16'h1A2B,
  parameter logic [15:0] VEN_ID     = 16'h3C4D,
  parameter logic [23:0] CLASS_CODE = 24'h078000,
  parameter logic [7:0]  REV_ID     = 8'h05,
  parameter logic [15:0] STATUS_VAL = 16'h0200,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h20,
  parameter logic [7:0]  MAX_LAT    = 8'h10
) (
  input  logic [OFS_W-1:0]  ofs,
  input  logic [3:0]        cmd_q,
  input  logic [CMDW_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0] bar_reg,
  input  logic [7:0]        int_line,
  output logic [DATA_W-1:0] rdata
);

  rd_sel_e sel;

  always_comb begin
    sel = RSEL_ZERO;
    if (cmd_q == BUS_CFG_RD) begin
      unique case (ofs)
        OFS_IDENT:   sel = RSEL_IDENT;
        OFS_CMDSTAT: sel = RSEL_CMDSTAT;
        OFS_CLASS:   sel = RSEL_CLASS;
        OFS_BASE0:   sel = RSEL_BASE;
        OFS_INTR:    sel = RSEL_INTR;
        default:     sel = RSEL_ZERO;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      RSEL_IDENT:   rdata = {DEV_ID, VEN_ID};
      RSEL_CMDSTAT: rdata = {STATUS_VAL, cmd_reg};
      RSEL_CLASS:   rdata = {CLASS_CODE, REV_ID};
      RSEL_BASE:    rdata = bar_reg;
      RSEL_INTR:    rdata = {MAX_LAT, MIN_GNT, INT_PIN, int_line};
      default:      rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfg_header_bank.sv
module cfg_header_bank
  import cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID        = 16'h1A2B,
  parameter logic [15:0] VEN_ID        = 16'h3C4D,
  parameter logic [23:0] CLASS_CODE    = 24'h078000,
  parameter logic [7:0]  REV_ID        = 8'h05,
  parameter logic [15:0] STATUS_VAL    = 16'h0200,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h20,
  parameter logic [7:0]  MAX_LAT       = 8'h10,
  parameter int unsigned BAR_SIZE_LOG2 = 12,
  parameter bit          BAR_IO        = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] addr_q,
  input  logic [3:0]  cmd_q,
  input  logic [3:0]  be_n,
  input  logic [31:0] wdata,
  input  logic        irdy_q_n,
  input  logic        trdy_n,
  output logic [31:0] rdata,
  output logic [15:0] cmd_reg,
  output logic [31:0] bar_reg,
  output logic [7:0]  int_line
);

  logic             srst_n;
  logic [OFS_W-1:0] ofs;
  logic [31:OFS_W]  unused_addr_hi;
  wr_strobe_t       strb;
  logic [LANES-1:0] lane_en;

  assign ofs            = addr_q[OFS_W-1:0];
  assign unused_addr_hi = addr_q[31:OFS_W];

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  cfg_wr_decode u_dec (
    .clk      (clk),
    .rst_n    (srst_n),
    .ofs      (ofs),
    .cmd_q    (cmd_q),
    .be_n     (be_n),
    .irdy_q_n (irdy_q_n),
    .trdy_n   (trdy_n),
    .strb     (strb),
    .lane_en  (lane_en)
  );

  cfg_regs #(
    .BAR_SIZE_LOG2 (BAR_SIZE_LOG2),
    .BAR_IO        (BAR_IO)
  ) u_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .strb    (strb),
    .lane_en (lane_en),
    .wdata   (wdata),
    .cmd_q   (cmd_reg),
    .bar_q   (bar_reg),
    .intl_q  (int_line)
  );

  cfg_rd_mux #(
    .DEV_ID     (DEV_ID),
    .VEN_ID     (VEN_ID),
    .CLASS_CODE (CLASS_CODE),
    .REV_ID     (REV_ID),
    .STATUS_VAL (STATUS_VAL),
    .INT_PIN    (INT_PIN),
    .MIN_GNT    (MIN_GNT),
    .MAX_LAT    (MAX_LAT)
  ) u_rd (
    .ofs      (ofs),
    .cmd_q    (cmd_q),
    .cmd_reg  (cmd_reg),
    .bar_reg  (bar_reg),
    .int_line (int_line),
    .rdata    (rdata)
  );

  AST_NO_WR_OFF_PHASE: assert property (@(posedge clk) disable iff (!srst_n)
    (irdy_q_n || trdy_n || (cmd_q != BUS_CFG_WR))
      |=> $stable({cmd_reg, bar_reg, int_line})) else $error("write outside data phase"); // R3
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_q != BUS_CFG_RD) |-> (rdata == '0)) else $error("read word without read command"); // R2
  AST_RD_BAR_MATCH: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_q == BUS_CFG_RD && ofs == OFS_BASE0) |-> (rdata == bar_reg)) else $error("base read mismatch"); // R9
  AST_BAR_FIXED_BIT: assert property (@(posedge clk) disable iff (!srst_n)
    bar_reg[0] == BAR_IO) else $error("space indicator lost"); // R1

endmodule

// File: tb/tb_cfg_header_bank.sv
module tb_cfg_header_bank;

  localparam logic [15:0] E_DEV    = 16'h1A2B;
  localparam logic [15:0] E_VEN    = 16'h3C4D;
  localparam logic [23:0] E_CLASS  = 24'h078000;
  localparam logic [7:0]  E_REV    = 8'h05;
  localparam logic [15:0] E_STAT   = 16'h0200;
  localparam logic [7:0]  E_PIN    = 8'h01;
  localparam logic [7:0]  E_MINGNT = 8'h20;
  localparam logic [7:0]  E_MAXLAT = 8'h10;
  localparam logic [3:0]  C_RD     = 4'b1010;
  localparam logic [3:0]  C_WR     = 4'b1011;
  localparam logic [3:0]  C_IDLE   = 4'b0000;

  logic        clk;
  logic        rst_n;
  logic [31:0] addr_q;
  logic [3:0]  cmd_q;
  logic [3:0]  be_n;
  logic [31:0] wdata;
  logic        irdy_q_n;
  logic        trdy_n;
  logic [31:0] rdata;
  logic [15:0] cmd_reg;
  logic [31:0] bar_reg;
  logic [7:0]  int_line;

  int checks;
  int errors;
  bit done;

  cfg_header_bank dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_q   (addr_q),
    .cmd_q    (cmd_q),
    .be_n     (be_n),
    .wdata    (wdata),
    .irdy_q_n (irdy_q_n),
    .trdy_n   (trdy_n),
    .rdata    (rdata),
    .cmd_reg  (cmd_reg),
    .bar_reg  (bar_reg),
    .int_line (int_line)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bus_idle();
    cmd_q    = C_IDLE;
    irdy_q_n = 1'b1;
    trdy_n   = 1'b1;
    be_n     = 4'hF;
    wdata    = '0;
  endtask

  task automatic phase(input logic [3:0] cmd, input logic [7:0] ofs, input logic [31:0] d,
                       input logic [3:0] ben, input logic irdy, input logic trdy);
    @(negedge clk);
    addr_q   = {24'h00AB00, ofs};
    cmd_q    = cmd;
    wdata    = d;
    be_n     = ben;
    irdy_q_n = irdy;
    trdy_n   = trdy;
    @(negedge clk);
    bus_idle();
    #2;
  endtask

  task automatic cfg_write(input logic [7:0] ofs, input logic [31:0] d, input logic [3:0] ben);
    phase(C_WR, ofs, d, ben, 1'b0, 1'b0);
  endtask

  task automatic cfg_read(input logic [3:0] cmd, input logic [7:0] ofs, output logic [31:0] val);
    @(negedge clk);
    addr_q = {24'h00CD00, ofs};
    cmd_q  = cmd;
    #2;
    val = rdata;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 command after reset", {16'h0, cmd_reg}, 32'h0);
    check("R1 base after reset", bar_reg, 32'h0);
    check("R1 int line after reset", {24'h0, int_line}, 32'h0);
    cfg_read(C_RD, 8'h04, v);
    check("R7 status/command after reset", v, {E_STAT, 16'h0000});
  endtask

  task automatic t_ident();
    logic [31:0] v;
    cfg_read(C_RD, 8'h00, v);
    check("R6 identity word", v, {E_DEV, E_VEN});
    cfg_read(C_RD, 8'h08, v);
    check("R6 class word", v, {E_CLASS, E_REV});
  endtask

  task automatic t_cmd_write();
    logic [31:0] v;
    cfg_write(8'h04, 32'hFFFF_0147, 4'b0000);
    check("R5 command full write", {16'h0, cmd_reg}, 32'h0000_0147);
    cfg_read(C_RD, 8'h04, v);
    check("R7 status fixed, command readback", v, {E_STAT, 16'h0147});
  endtask

  task automatic t_byte_lanes();
    cfg_write(8'h04, 32'h0000_AA55, 4'b1110);
    check("R5 lane 0 only", {16'h0, cmd_reg}, 32'h0000_0155);
    cfg_write(8'h04, 32'h0000_0300, 4'b1101);
    check("R5 lane 1 only", {16'h0, cmd_reg}, 32'h0000_0355);
    cfg_write(8'h04, 32'hFFFF_FFFF, 4'b1111);
    check("R5 no lane enabled", {16'h0, cmd_reg}, 32'h0000_0355);
  endtask

  task automatic t_handshake();
    phase(C_WR, 8'h3C, 32'h0000_00C3, 4'b0000, 1'b1, 1'b0);
    check("R3 initiator not ready", {24'h0, int_line}, 32'h0);
    phase(C_WR, 8'h3C, 32'h0000_00C3, 4'b0000, 1'b0, 1'b1);
    check("R3 target not ready", {24'h0, int_line}, 32'h0);
    phase(4'b0111, 8'h3C, 32'h0000_00C3, 4'b0000, 1'b0, 1'b0);
    check("R3 memory write command", {24'h0, int_line}, 32'h0);
    phase(4'b0011, 8'h04, 32'h0000_FFFF, 4'b0000, 1'b0, 1'b0);
    check("R3 io write command", {16'h0, cmd_reg}, 32'h0000_0355);
  endtask

  task automatic t_bar();
    logic [31:0] v;
    cfg_write(8'h10, 32'hFFFF_FFFF, 4'b0000);
    check("R9 sizing mask on output", bar_reg, 32'hFFFF_F000);
    cfg_read(C_RD, 8'h10, v);
    check("R9 sizing mask readback", v, 32'hFFFF_F000);
    cfg_write(8'h10, 32'h1234_5678, 4'b0000);
    check("R9 base address value", bar_reg, 32'h1234_5000);
    cfg_write(8'h10, 32'hAB00_0000, 4'b0111);
    check("R5 base top lane only", bar_reg, 32'hAB34_5000);
  endtask

  task automatic t_intr();
    logic [31:0] v;
    cfg_write(8'h3C, 32'hFFFF_FF5A, 4'b0000);
    check("R8 int line write", {24'h0, int_line}, 32'h0000_005A);
    cfg_read(C_RD, 8'h3C, v);
    check("R8 interrupt word", v, {E_MAXLAT, E_MINGNT, E_PIN, 8'h5A});
    cfg_write(8'h3C, 32'h0000_0077, 4'b1110);
    check("R8 lane 0 write", {24'h0, int_line}, 32'h0000_0077);
    cfg_write(8'h3C, 32'h0000_0099, 4'b0001);
    check("R8 lane 0 disabled", {24'h0, int_line}, 32'h0000_0077);
  endtask

  task automatic t_discard();
    logic [31:0] v;
    cfg_write(8'h00, 32'hFFFF_FFFF, 4'b0000);
    cfg_write(8'h08, 32'hFFFF_FFFF, 4'b0000);
    cfg_write(8'h14, 32'hFFFF_FFFF, 4'b0000);
    cfg_write(8'h40, 32'hFFFF_FFFF, 4'b0000);
    cfg_write(8'h05, 32'hFFFF_FFFF, 4'b0000);
    cfg_write(8'h11, 32'hFFFF_FFFF, 4'b0000);
    cfg_write(8'h3D, 32'hFFFF_FFFF, 4'b0000);
    check("R4 command untouched", {16'h0, cmd_reg}, 32'h0000_0355);
    check("R4 base untouched", bar_reg, 32'hAB34_5000);
    check("R4 int line untouched", {24'h0, int_line}, 32'h0000_0077);
    cfg_read(C_RD, 8'h00, v);
    check("R4 identity still fixed", v, {E_DEV, E_VEN});
  endtask

  task automatic t_zero_reads();
    logic [31:0] v;
    logic [7:0] ofs_list [7] = '{8'h0C, 8'h14, 8'h34, 8'h38, 8'h40, 8'hFC, 8'h05};
    for (int i = 0; i < 7; i++) begin
      cfg_read(C_RD, ofs_list[i], v);
      check($sformatf("R10 zero read at %02h", ofs_list[i]), v, 32'h0);
    end
  endtask

  task automatic t_read_gate();
    logic [31:0] v;
    cfg_read(4'b0110, 8'h00, v);
    check("R2 memory read gives zero", v, 32'h0);
    cfg_read(C_WR, 8'h10, v);
    check("R2 config write gives zero", v, 32'h0);
    cfg_read(C_RD, 8'h10, v);
    check("R2 config read gives data", v, 32'hAB34_5000);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    addr_q = '0;
    bus_idle();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ident();
    t_cmd_write();
    t_byte_lanes();
    t_handshake();
    t_bar();
    t_intr();
    t_discard();
    t_zero_reads();
    t_read_gate();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule